// File: doc/BRIEF.md
# Scatter-Gather Descriptor Submission Arbiter

This block sits between several streaming DMA channels and one shared DMA descriptor port. Each channel's preparation logic raises an availability flag and holds a descriptor: byte count, flags, user tag and buffer address. The arbiter visits the channels one at a time in a fixed circular order. It passes over any channel that has nothing ready. For a ready channel it asks the DMA side to reserve the shared port for that channel and waits for a grant. It then captures the channel's fields, packs them into one padded element and offers that element until the DMA side acknowledges it.

Each wait has its own timer, and the two timers recover in different ways. A grant that does not come in time makes the arbiter give up on that channel quietly and move to the next one. An acknowledge that does not come in time sends an error pulse back to the channel. A successful acknowledge sends a done pulse. Both outcomes advance the circular pointer past the channel that was just served, so a busy channel cannot starve the others.

The address can be 32 or 64 bits wide, chosen at build time. Any element bits above the packed descriptor are filled with zeros inside this block.

Top module: `sg_submit_arb`

## Requirements
- R1: Channels are visited in increasing index order, wrapping after the last. A channel whose `ch_avail` bit is low is passed over without raising `rsv_req`.
- R2: For a ready channel, `rsv_req` rises with `rsv_ch` equal to that channel's index. `rsv_ch` stays constant while `rsv_req` is held.
- R3: If `rsv_grant` has not been seen after `GRANT_TMO` cycles of `rsv_req`, the request drops, the channel gets neither done nor error, and polling moves on to the next channel.
- R4: The element packs byte count in bits [23:0], flags in [31:24], user tag in [47:32] and address from bit 48 up (32 bits wide by default, 64 bits when `ADDR64` is 1).
- R5: Element bits above the packed descriptor (bits [127:80] by default) are zero.
- R6: While `sub_valid` is high and no acknowledge has arrived, `sub_valid` and `sub_data` stay unchanged until the acknowledge timer runs out.
- R7: An acknowledge makes `ch_done` pulse for exactly one cycle, in the cycle after the acknowledge, on the bit of the channel that was served. `ch_err` stays low.
- R8: If `sub_ack` has not arrived after `ACK_TMO` cycles of `sub_valid`, `sub_valid` drops and `ch_err` pulses for one cycle on the served channel's bit. `ch_done` stays low.
- R9: After any completion or grant timeout, the next channel examined is the one after the channel just handled. The request is released in the same cycle that done or error is reported.
- R10: While reset is active and just after it, `rsv_req`, `sub_valid`, `ch_done` and `ch_err` are low, and polling starts at channel 0.
- R11: A grant that arrives in the last cycle of the grant window is accepted. An acknowledge that arrives in the last cycle of the acknowledge window produces done, not error.
- R12: `sub_valid` is high only while `rsv_req` is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized internally |
| ch_avail | input | NUM_CH | Per-channel descriptor-ready flags |
| ch_bcnt | input | NUM_CH*24 | Per-channel byte counts, channel 0 in the low slice |
| ch_flags | input | NUM_CH*8 | Per-channel direction flags |
| ch_utag | input | NUM_CH*16 | Per-channel user tags |
| ch_addr | input | NUM_CH*ADDR_W | Per-channel buffer addresses (ADDR_W is 32 or 64) |
| ch_done | output | NUM_CH | One-cycle completion pulse for each channel |
| ch_err | output | NUM_CH | One-cycle acknowledge-timeout pulse for each channel |
| rsv_req | output | 1 | Request to reserve the shared descriptor port |
| rsv_ch | output | CH_W | Channel the reservation is for |
| rsv_grant | input | 1 | Reservation granted |
| sub_valid | output | 1 | Packed element offered |
| sub_data | output | ELEM_W | Packed and padded element |
| sub_ack | input | 1 | Element accepted |

## Verification
The hardest collisions are a handshake input arriving in the very cycle its timer expires. This can be a grant in the final cycle of the grant window, or an acknowledge in the final cycle of the acknowledge window. The bench counts the cycles of `rsv_req` and `sub_valid` at the ports and raises each input exactly in the last cycle of its window. It then requires a submission in the first case and a done pulse with no error pulse in the second. The opposite collision is also checked: a timeout on one channel followed directly by another channel's request. Here the bench requires that the abandoned channel receives no pulse and that the next channel index appears.

// File: rtl/sgs_pkg.sv
package sgs_pkg;
  // descriptor field layout: the DMA side decodes these positions
  localparam int BCNT_W  = 24;
  localparam int FLAG_W  = 8;
  localparam int UTAG_W  = 16;
  localparam int ADDR_LSB = BCNT_W + FLAG_W + UTAG_W;

  typedef enum logic [1:0] {
    ST_POLL = 2'd0,
    ST_RSV  = 2'd1,
    ST_SUB  = 2'd2
  } sgs_state_e;
endpackage

// File: rtl/sgs_rst_sync.sv
module sgs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sgs_timer.sv
module sgs_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run)        cnt_d = '0;
    else if (last)   cnt_d = cnt_q;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = run && (cnt_q == LAST_V);
endmodule

// File: rtl/sgs_rr_ptr.sv
module sgs_rr_ptr #(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  output logic [CH_W-1:0] ptr
);
  localparam logic [CH_W-1:0] TOP = CH_W'(NUM_CH - 1);

  logic [CH_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) ptr_d = (ptr_q == TOP) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/sgs_pack.sv
module sgs_pack import sgs_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int ELEM_W = 128
) (
  input  logic [BCNT_W-1:0] bcnt,
  input  logic [FLAG_W-1:0] flags,
  input  logic [UTAG_W-1:0] utag,
  input  logic [ADDR_W-1:0] addr,
  output logic [ELEM_W-1:0] elem
);
  localparam int DESC_W = ADDR_LSB + ADDR_W;

  logic [DESC_W-1:0] desc;
  assign desc = {addr, utag, flags, bcnt};

  generate
    if (ELEM_W > DESC_W) begin : g_pad
      assign elem = {{(ELEM_W - DESC_W){1'b0}}, desc};
    end else begin : g_nopad
      assign elem = desc[ELEM_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/sg_submit_arb.sv
module sg_submit_arb import sgs_pkg::*; #(
  parameter int NUM_CH    = 4,
  parameter int ADDR64    = 0,
  parameter int ELEM_W    = 128,
  parameter int GRANT_TMO = 16,
  parameter int ACK_TMO   = 32,
  localparam int ADDR_W = (ADDR64 != 0) ? 64 : 32,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        ch_avail,
  input  logic [NUM_CH*BCNT_W-1:0] ch_bcnt,
  input  logic [NUM_CH*FLAG_W-1:0] ch_flags,
  input  logic [NUM_CH*UTAG_W-1:0] ch_utag,
  input  logic [NUM_CH*ADDR_W-1:0] ch_addr,
  output logic [NUM_CH-1:0]        ch_done,
  output logic [NUM_CH-1:0]        ch_err,
  output logic                     rsv_req,
  output logic [CH_W-1:0]          rsv_ch,
  input  logic                     rsv_grant,
  output logic                     sub_valid,
  output logic [ELEM_W-1:0]        sub_data,
  input  logic                     sub_ack
);
  logic            rst_i_n;
  sgs_state_e      state_q, state_d;
  logic [CH_W-1:0] ptr;
  logic            adv;
  logic            load_en;
  logic            g_last, a_last;
  logic [NUM_CH-1:0] done_d, err_d, done_q, err_q;
  logic [ELEM_W-1:0] elem_w, elem_q;

  sgs_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  sgs_rr_ptr #(.NUM_CH(NUM_CH)) u_ptr (
    .clk(clk), .rst_n(rst_i_n), .adv(adv), .ptr(ptr)
  );

  sgs_timer #(.LIMIT(GRANT_TMO)) u_gtmr (
    .clk(clk), .rst_n(rst_i_n), .run(state_q == ST_RSV), .last(g_last)
  );

  sgs_timer #(.LIMIT(ACK_TMO)) u_atmr (
    .clk(clk), .rst_n(rst_i_n), .run(state_q == ST_SUB), .last(a_last)
  );

  sgs_pack #(.ADDR_W(ADDR_W), .ELEM_W(ELEM_W)) u_pack (
    .bcnt (ch_bcnt [ptr*BCNT_W +: BCNT_W]),
    .flags(ch_flags[ptr*FLAG_W +: FLAG_W]),
    .utag (ch_utag [ptr*UTAG_W +: UTAG_W]),
    .addr (ch_addr [ptr*ADDR_W +: ADDR_W]),
    .elem (elem_w)
  );

  // next-state and strobes
  always_comb begin
    state_d = state_q;
    adv     = 1'b0;
    load_en = 1'b0;
    done_d  = '0;
    err_d   = '0;
    unique case (state_q)
      ST_POLL: begin
        if (ch_avail[ptr]) state_d = ST_RSV;
        else               adv = 1'b1;
      end
      ST_RSV: begin
        if (rsv_grant) begin
          state_d = ST_SUB;
          load_en = 1'b1;
        end else if (g_last) begin
          state_d = ST_POLL;
          adv     = 1'b1;
        end
      end
      ST_SUB: begin
        if (sub_ack) begin
          state_d     = ST_POLL;
          adv         = 1'b1;
          done_d[ptr] = 1'b1;
        end else if (a_last) begin
          state_d    = ST_POLL;
          adv        = 1'b1;
          err_d[ptr] = 1'b1;
        end
      end
      default: state_d = ST_POLL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_POLL;
      done_q  <= '0;
      err_q   <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  // element holding register, enabled only on grant
  always_ff @(posedge clk) begin
    if (load_en) elem_q <= elem_w;
  end

  assign rsv_req   = (state_q != ST_POLL);
  assign rsv_ch    = ptr;
  assign sub_valid = (state_q == ST_SUB);
  assign sub_data  = elem_q;
  assign ch_done   = done_q;
  assign ch_err    = err_q;
endmodule

// File: rtl/sgs_submit_chk.sv
module sgs_submit_chk #(
  parameter int NUM_CH    = 4,
  parameter int CH_W      = 2,
  parameter int ELEM_W    = 128,
  parameter int GRANT_TMO = 16,
  parameter int ACK_TMO   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ch_done,
  input logic [NUM_CH-1:0] ch_err,
  input logic              rsv_req,
  input logic [CH_W-1:0]   rsv_ch,
  input logic              sub_valid,
  input logic [ELEM_W-1:0] sub_data,
  input logic              sub_ack
);
  logic [31:0] g_cnt, a_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_cnt <= '0;
      a_cnt <= '0;
    end else begin
      g_cnt <= (rsv_req && !sub_valid) ? g_cnt + 1 : '0;
      a_cnt <= sub_valid ? a_cnt + 1 : '0;
    end
  end

  assert_ch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_req |=> (!rsv_req || $stable(rsv_ch)));

  assert_grant_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_req && !sub_valid) |-> (g_cnt < GRANT_TMO));

  assert_hold_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && !sub_ack && (a_cnt < ACK_TMO - 1)) |=> (sub_valid && $stable(sub_data)));

  assert_done_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_done) |-> $past(sub_valid && sub_ack));

  assert_pulse_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ch_done, ch_err}));

  assert_ack_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |-> (a_cnt < ACK_TMO));

  assert_err_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_err) |=> (ch_err == '0));

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ch_done) || (|ch_err)) |-> (!rsv_req && !sub_valid));

  assert_valid_reserved_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |-> rsv_req);
endmodule

bind sg_submit_arb sgs_submit_chk #(
  .NUM_CH(NUM_CH), .CH_W(CH_W), .ELEM_W(ELEM_W),
  .GRANT_TMO(GRANT_TMO), .ACK_TMO(ACK_TMO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_done(ch_done), .ch_err(ch_err),
  .rsv_req(rsv_req), .rsv_ch(rsv_ch), .sub_valid(sub_valid),
  .sub_data(sub_data), .sub_ack(sub_ack)
);

// File: tb/sg_submit_arb_test.sv
`timescale 1ns/1ps
module sg_submit_arb_test;
  localparam int NCH  = 4;
  localparam int GT   = 16;
  localparam int AT   = 32;
  localparam int EW   = 128;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0]    ch_avail;
  logic [NCH*24-1:0] ch_bcnt;
  logic [NCH*8-1:0]  ch_flags;
  logic [NCH*16-1:0] ch_utag;
  logic [NCH*32-1:0] ch_addr;
  logic [NCH-1:0]    ch_done, ch_err;
  logic              rsv_req, rsv_grant, sub_valid, sub_ack;
  logic [1:0]        rsv_ch;
  logic [EW-1:0]     sub_data;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  sg_submit_arb #(.NUM_CH(NCH), .ADDR64(0), .ELEM_W(EW),
                  .GRANT_TMO(GT), .ACK_TMO(AT)) uut (
    .clk(clk), .rst_n(rst_n), .ch_avail(ch_avail), .ch_bcnt(ch_bcnt),
    .ch_flags(ch_flags), .ch_utag(ch_utag), .ch_addr(ch_addr),
    .ch_done(ch_done), .ch_err(ch_err), .rsv_req(rsv_req), .rsv_ch(rsv_ch),
    .rsv_grant(rsv_grant), .sub_valid(sub_valid), .sub_data(sub_data),
    .sub_ack(sub_ack)
  );

  function automatic logic [EW-1:0] exp_elem(int ch);
    return {48'h0, 32'h1000_0000 + 32'(ch) * 32'h100, 16'hC000 + 16'(ch),
            8'h80 | 8'(ch), 24'h000100 + 24'(ch) * 24'h10};
  endfunction

  task automatic chk(bit ok, string req, logic [EW-1:0] act, logic [EW-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wait_req();
    int n = 0;
    while (!rsv_req && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(rsv_req, "R1 request never raised", rsv_req, 1);
  endtask

  task automatic pulse_grant();
    rsv_grant = 1'b1;
    @(negedge clk);
    rsv_grant = 1'b0;
  endtask

  // serve one channel with immediate grant and acknowledge
  task automatic serve(int ch, string tag);
    wait_req();
    chk(rsv_ch == 2'(ch), {tag, " channel order"}, rsv_ch, ch);
    pulse_grant();
    sub_ack = 1'b1;
    @(negedge clk);
    sub_ack = 1'b0;
    chk(ch_done == 4'(1 << ch) && ch_err == '0, {tag, " done pulse"}, ch_done, 1 << ch);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ch_avail = '0; rsv_grant = 0; sub_ack = 0;
    for (int c = 0; c < NCH; c++) begin
      ch_bcnt [c*24 +: 24] = 24'h000100 + 24'(c) * 24'h10;
      ch_flags[c*8  +: 8]  = 8'h80 | 8'(c);
      ch_utag [c*16 +: 16] = 16'hC000 + 16'(c);
      ch_addr [c*32 +: 32] = 32'h1000_0000 + 32'(c) * 32'h100;
    end
    repeat (3) @(negedge clk);
    chk(!rsv_req && !sub_valid && ch_done == 0 && ch_err == 0, "R10 in reset",
        {rsv_req, sub_valid, ch_done, ch_err}, 0);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    chk(!rsv_req && ch_done == 0 && ch_err == 0, "R1/R10 idle with nothing ready",
        {rsv_req, ch_done, ch_err}, 0);
    // resync pointer to channel 0 for the following scenarios
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_rr_skip();
    logic [EW-1:0] snap;
    ch_avail = 4'b1010;
    wait_req();
    chk(rsv_ch == 2'd1, "R1 R2 skip channel 0", rsv_ch, 1);
    pulse_grant();
    chk(sub_valid, "R2 valid after grant", sub_valid, 1);
    chk(sub_data == exp_elem(1), "R4 packed fields", sub_data, exp_elem(1));
    chk(sub_data[127:80] == '0, "R5 zero padding", sub_data[127:80], 0);
    snap = sub_data;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(sub_valid && sub_data == snap, "R6 hold until ack", sub_data, snap);
    end
    sub_ack = 1'b1;
    @(negedge clk);
    sub_ack = 1'b0;
    ch_avail[1] = 1'b0;
    chk(ch_done == 4'b0010 && ch_err == 0, "R7 done on channel 1", ch_done, 4'b0010);
    chk(!rsv_req, "R9 request released with done", rsv_req, 0);
    @(negedge clk);
    chk(ch_done == 0, "R7 done lasts one cycle", ch_done, 0);
    serve(3, "R9 then channel 3");
    ch_avail = '0;
  endtask

  task automatic t_grant_timeout();
    int cnt;
    bit saw = 0;
    ch_avail = 4'b0011;
    wait_req();
    chk(rsv_ch == 2'd0, "R1 wrap to channel 0", rsv_ch, 0);
    cnt = 1;
    forever begin
      @(negedge clk);
      if (ch_done != 0 || ch_err != 0) saw = 1;
      if (!rsv_req) break;
      cnt++;
    end
    chk(cnt == GT, "R3 grant window length", cnt, GT);
    chk(!saw, "R3 no pulse on grant timeout", saw, 0);
    wait_req();
    chk(rsv_ch == 2'd1, "R3 R9 next channel after timeout", rsv_ch, 1);
    pulse_grant();
    cnt = 1;
    forever begin
      @(negedge clk);
      if (!sub_valid) break;
      cnt++;
    end
    chk(cnt == AT, "R8 ack window length", cnt, AT);
    chk(ch_err == 4'b0010 && ch_done == 0, "R8 error on channel 1", ch_err, 4'b0010);
    ch_avail = '0;
    @(negedge clk);
    chk(ch_err == 0, "R8 error lasts one cycle", ch_err, 0);
  endtask

  task automatic t_last_cycle();
    int cnt;
    ch_avail = 4'b0100;
    wait_req();
    chk(rsv_ch == 2'd2, "R9 channel 2 after channel 1", rsv_ch, 2);
    cnt = 1;
    while (cnt < GT) begin
      @(negedge clk);
      cnt++;
    end
    chk(rsv_req && !sub_valid, "R11 still waiting in last grant cycle", rsv_req, 1);
    pulse_grant();
    chk(sub_valid, "R11 late grant accepted", sub_valid, 1);
    cnt = 1;
    while (cnt < AT) begin
      @(negedge clk);
      cnt++;
    end
    chk(sub_valid, "R11 still valid in last ack cycle", sub_valid, 1);
    sub_ack = 1'b1;
    @(negedge clk);
    sub_ack = 1'b0;
    ch_avail = '0;
    chk(ch_done == 4'b0100 && ch_err == 0, "R11 late ack gives done",
        {ch_done, ch_err}, {4'b0100, 4'b0000});
  endtask

  task automatic t_fair();
    ch_avail = 4'b1111;
    serve(3, "R9 fair 3");
    serve(0, "R9 fair 0");
    serve(1, "R9 fair 1");
    serve(2, "R9 fair 2");
    ch_avail = '0;
  endtask

  initial begin
    #(4 * 150000);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_rr_skip();
    t_grant_timeout();
    t_last_cycle();
    t_fair();
    repeat (4) @(negedge clk);
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule